// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block is a real-time calendar counter. It holds the hundredths of a second, seconds, minutes, hours, weekday, day of month, month and two-digit year as packed BCD bytes and moves the whole calendar forward by one hundredth each time the 100 Hz `tick` enable is high. The eight bytes are always visible together on `time_regs`, with byte k at bits `8k+7:8k`.

An access controller writes a complete 64-bit image through a valid/ready load port. `load_ready` is held high, so the port never applies back-pressure. A beat is taken on every cycle in which `load_valid` is high, and it shows on `time_regs` one cycle later. A load wins over a tick in the same cycle, and the next tick counts onward from the loaded values. Bits that are reserved are cleared as the image is taken in, so they always read back as zero.

The hour byte and the weekday byte also carry mode bits. Hour bit 7 selects 12-hour mode. In 12-hour mode hour bit 5 is the PM flag, and in 24-hour mode it is the second tens digit. Weekday bit 5 stops the oscillator, and weekday bit 4 is a stored reset-enable flag that software reads back.

Top module: `bcd_calendar_core`

## Requirements
- R1: With the clock running, each tick adds one to the hundredths byte (byte 0, 00–99). 99 wraps to 00 and adds one to seconds (byte 1). Seconds wrap 59→00 into minutes (byte 2), and minutes wrap 59→00 into the hour.
- R2: With hour bit 7 clear (24-hour mode), byte 3 counts 00–23 in BCD, with bits 5:4 as the tens digit. A carry into 23 makes it 00 and advances the day.
- R3: With hour bit 7 set (12-hour mode), bits 4:0 count 01–12 and bit 5 is PM (1 = PM). A carry into 11 gives 12 and toggles PM. A carry into 12 gives 01. Going from 11 PM to 12 AM advances the day.
- R4: The date (byte 5) wraps to 01 after the last day of the month and the month advances. Months 04, 06, 09 and 11 end at 30, February ends at 28 or 29, and all others end at 31. Month (byte 6) wraps 12→01 and adds one to the year (byte 7), which wraps 99→00.
- R5: A year whose value is divisible by 4 is a leap year, year 00 included, and its February ends at 29.
- R6: The weekday (byte 4, bits 2:0, 01–07) advances whenever the date advances and wraps 07→01.
- R7: While byte 4 bit 5 is 1, ticks have no effect and every byte holds its value. While it is 0, the clock runs.
- R8: These bits always read 0 whatever is loaded: byte 1 bit 7, byte 2 bit 7, byte 3 bit 6, byte 4 bits 7, 6 and 3, byte 5 bits 7:6, byte 6 bits 7:5.
- R9: After reset, `time_regs` is 64'h0001013100000000. That is 24-hour 00:00:00.00, weekday 01 with bits 5 and 4 set, date 01, month 01, year 00.
- R10: `load_ready` is always 1. A beat with `load_valid` high appears on `time_regs` after the next clock edge even if `tick` is high in that cycle, and later ticks count from the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 100 Hz advance enable, one cycle wide |
| load_valid | input | 1 | Load beat present |
| load_ready | output | 1 | Load accepted (always 1) |
| load_data | input | 64 | Full register image, byte k at bits 8k+7:8k |
| time_regs | output | 64 | Current register image, same layout |

## Verification
Every cycle, the assertions check these behaviours: the sub-second, second and minute wraps, the 23→00 and 12→01 hour steps, the date rolling to 01 at month end, the leap-year February step, the weekday and year wraps, the frozen image while the oscillator is stopped, the zero bits, and a load winning over a tick. Only the bench scenarios show the whole calendar. They sweep all 100 years for February, every month in a leap year and in a common year, every hour value in both formats, and long runs across midnight and New Year. They also show the exact reset image and that the load port never stalls.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int IMG_W    = REG_W * NUM_REGS;

  // bits that may hold a value; everything else reads zero (byte 7 .. byte 0)
  localparam logic [IMG_W-1:0] KEEP_MASK =
    {8'hFF, 8'h1F, 8'h3F, 8'h37, 8'hBF, 8'h7F, 8'h7F, 8'hFF};

  localparam logic [IMG_W-1:0] RESET_IMG = 64'h0001013100000000;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_wrap_counter.sv
module bcd_wrap_counter
  import bcd_cal_pkg::*;
#(
  parameter logic [7:0] FIRST = 8'h00,
  parameter logic [7:0] LAST  = 8'h99,
  parameter logic [7:0] INIT  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  logic [7:0] load_val,
  input  logic       inc,
  output logic [7:0] val,
  output logic       wrap
);
  assign wrap = inc && (val >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       val <= INIT;
    else if (load_en) val <= load_val;
    else if (wrap)    val <= FIRST;
    else if (inc)     val <= bcd_inc(val);
  end

  // R1 / R4 / R6: a carry at the top value lands on the first value
  a_r1_wrap_first: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_en && val == LAST) |=> (val == FIRST));
endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  logic [7:0] load_val,
  input  logic       inc,
  output logic [7:0] hour,
  output logic       day_carry
);
  logic       mode12, pm;
  logic [4:0] v12;
  logic [5:0] v24;
  logic [7:0] inc12, inc24, nxt;

  assign mode12 = hour[7];
  assign pm     = hour[5];
  assign v12    = hour[4:0];
  assign v24    = hour[5:0];
  assign inc12  = bcd_inc({3'b000, v12});
  assign inc24  = bcd_inc({2'b00, v24});

  always_comb begin
    nxt       = hour;
    day_carry = 1'b0;
    if (inc) begin
      if (mode12) begin
        if (v12 == 5'h11) begin
          nxt       = {2'b10, ~pm, 5'h12};
          day_carry = pm;
        end else if (v12 >= 5'h12) begin
          nxt = {2'b10, pm, 5'h01};
        end else begin
          nxt = {2'b10, pm, inc12[4:0]};
        end
      end else begin
        if (v24 >= 6'h23) begin
          nxt       = 8'h00;
          day_carry = 1'b1;
        end else begin
          nxt = {2'b00, inc24[5:0]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hour <= 8'h00;
    else if (load_en) hour <= load_val;
    else              hour <= nxt;
  end

  // R2: 23 wraps to 00 in 24-hour mode
  a_r2_wrap_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_en && hour == 8'h23) |=> (hour == 8'h00));
  // R3: 12 steps to 01 keeping the PM flag
  a_r3_twelve_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_en && mode12 && v12 == 5'h12) |=> (hour[4:0] == 5'h01 && hour[5] == $past(pm)));
  // R3: 11 steps to 12 with PM toggled
  a_r3_eleven_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_en && mode12 && v12 == 5'h11) |=> (hour[4:0] == 5'h12 && hour[5] != $past(pm)));
endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  logic [7:0] load_day,
  input  logic [7:0] load_date,
  input  logic [7:0] load_month,
  input  logic [7:0] load_year,
  input  logic       inc_day,
  output logic [7:0] day_reg,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year
);
  logic [1:0] mode_q;
  logic [7:0] dow, last;
  logic       dow_wrap, date_wrap, month_wrap, year_wrap, leap;

  assign leap      = is_leap(year);
  assign last      = month_last(month, leap);
  assign date_wrap = inc_day && (date >= last);
  assign day_reg   = {2'b00, mode_q, 4'b0000} | dow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 2'b11;
    else if (load_en) mode_q <= load_day[5:4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         date <= 8'h01;
    else if (load_en)   date <= load_date;
    else if (date_wrap) date <= 8'h01;
    else if (inc_day)   date <= bcd_inc(date);
  end

  bcd_wrap_counter #(.FIRST(8'h01), .LAST(8'h07), .INIT(8'h01)) u_dow (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_day & 8'h07),
    .inc(inc_day), .val(dow), .wrap(dow_wrap));

  bcd_wrap_counter #(.FIRST(8'h01), .LAST(8'h12), .INIT(8'h01)) u_month (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_month),
    .inc(date_wrap), .val(month), .wrap(month_wrap));

  bcd_wrap_counter #(.FIRST(8'h00), .LAST(8'h99), .INIT(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_year),
    .inc(month_wrap), .val(year), .wrap(year_wrap));

  // R4: the month's last date rolls to 01
  a_r4_date_roll: assert property (@(posedge clk) disable iff (!rst_n)
    (date_wrap && !load_en && date == last) |=> (date == 8'h01));
  // R4: year 99 rolls to 00
  a_r4_year_roll: assert property (@(posedge clk) disable iff (!rst_n)
    (year_wrap && !load_en) |=> (year == 8'h00));
  // R5: February 28 steps to 29 in a leap year
  a_r5_leap_feb: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_day && !load_en && month == 8'h02 && date == 8'h28 && leap) |=> (date == 8'h29));
  // R6: weekday 07 rolls to 01
  a_r6_dow_roll: assert property (@(posedge clk) disable iff (!rst_n)
    (dow_wrap && !load_en) |=> (day_reg[2:0] == 3'd1));
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import bcd_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [IMG_W-1:0] load_data,
  output logic [IMG_W-1:0] time_regs
);
  localparam int CHAIN = 3;  // hundredths, seconds, minutes

  logic             load_fire, running;
  logic [IMG_W-1:0] img_in;
  logic [CHAIN:0]   carry;
  logic [7:0]       chain_val [CHAIN];
  logic [7:0]       hour, day_reg, date, month, year;
  logic             day_carry;

  assign load_ready = 1'b1;
  assign load_fire  = load_valid && load_ready;
  assign img_in     = load_data & KEEP_MASK;
  assign running    = ~day_reg[5];
  assign carry[0]   = tick && running;

  for (genvar i = 0; i < CHAIN; i++) begin : g_chain
    localparam logic [7:0] TOP = (i == 0) ? 8'h99 : 8'h59;
    bcd_wrap_counter #(.FIRST(8'h00), .LAST(TOP), .INIT(8'h00)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_en(load_fire),
      .load_val(img_in[REG_W*i +: REG_W]), .inc(carry[i]),
      .val(chain_val[i]), .wrap(carry[i+1]));
  end

  cal_hour_unit u_hour (
    .clk(clk), .rst_n(rst_n), .load_en(load_fire), .load_val(img_in[31:24]),
    .inc(carry[CHAIN]), .hour(hour), .day_carry(day_carry));

  cal_date_unit u_date (
    .clk(clk), .rst_n(rst_n), .load_en(load_fire),
    .load_day(img_in[39:32]), .load_date(img_in[47:40]),
    .load_month(img_in[55:48]), .load_year(img_in[63:56]),
    .inc_day(day_carry), .day_reg(day_reg), .date(date),
    .month(month), .year(year));

  assign time_regs = {year, month, date, day_reg, hour,
                      chain_val[2], chain_val[1], chain_val[0]};

  // R7: a stopped oscillator freezes the image
  a_r7_osc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_valid && time_regs[37]) |=> $stable(time_regs));
  // R8: reserved bits stay zero
  a_r8_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((time_regs & ~KEEP_MASK) == '0));
  // R10: a load wins over a tick in the same cycle
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> (time_regs[7:0] == $past(load_data[7:0]) &&
                    time_regs[63:56] == $past(load_data[63:56])));
  // R10: never back-pressure
  a_r10_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    load_ready);
endmodule

// File: tb/bcd_calendar_core_test.sv
module bcd_calendar_core_test;
  logic        clk = 1'b0;
  logic        rst_n, tick, load_valid, load_ready;
  logic [63:0] load_data, time_regs;

  always #4 clk = ~clk;

  bcd_calendar_core uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_valid(load_valid),
    .load_ready(load_ready), .load_data(load_data), .time_regs(time_regs));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state, binary integers
  int e_hund, e_sec, e_min, e_hr, e_pm, e_h12, e_dow, e_date, e_mon, e_yr, e_osc, e_rsten;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] pack_model();
    logic [7:0] hb, db, tb;
    tb = to_bcd(e_hr);
    hb = e_h12 ? {2'b10, e_pm[0], tb[4:0]} : tb;
    db = {2'b00, e_osc[0], e_rsten[0], 1'b0, 3'(e_dow)};
    return {to_bcd(e_yr), to_bcd(e_mon), to_bcd(e_date), db, hb,
            to_bcd(e_min), to_bcd(e_sec), to_bcd(e_hund)};
  endfunction

  task automatic next_day();
    e_dow = (e_dow == 7) ? 1 : e_dow + 1;
    e_date++;
    if (e_date > days_in(e_mon, e_yr)) begin
      e_date = 1;
      e_mon++;
      if (e_mon > 12) begin
        e_mon = 1;
        e_yr  = (e_yr + 1) % 100;
      end
    end
  endtask

  task automatic model_tick();
    if (e_osc != 0) return;
    e_hund++;
    if (e_hund < 100) return;
    e_hund = 0; e_sec++;
    if (e_sec < 60) return;
    e_sec = 0; e_min++;
    if (e_min < 60) return;
    e_min = 0;
    if (e_h12 != 0) begin
      if (e_hr == 11) begin
        e_hr = 12; e_pm = 1 - e_pm;
        if (e_pm == 0) next_day();
      end else if (e_hr == 12) e_hr = 1;
      else e_hr++;
    end else begin
      e_hr++;
      if (e_hr == 24) begin
        e_hr = 0;
        next_day();
      end
    end
  endtask

  task automatic set_model(input int hu, input int s, input int mi, input int hr,
                           input int pm, input int h12, input int dw, input int dt,
                           input int mo, input int yr, input int osc, input int rs);
    e_hund = hu; e_sec = s; e_min = mi; e_hr = hr; e_pm = pm; e_h12 = h12;
    e_dow = dw; e_date = dt; e_mon = mo; e_yr = yr; e_osc = osc; e_rsten = rs;
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_load(input string tag, input logic with_tick);
    @(negedge clk);
    load_valid = 1'b1;
    load_data  = pack_model();
    tick       = with_tick;
    check({tag, " R10 ready"}, {63'd0, load_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    load_valid = 1'b0;
    tick       = 1'b0;
    check(tag, time_regs, pack_model());
  endtask

  task automatic run_ticks(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      model_tick();
      check(tag, time_regs, pack_model());
    end
    tick = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; load_valid = 1'b0; load_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R9 reset image
    check("R9 reset image", time_regs, 64'h0001013100000000);

    // R7 oscillator stopped out of reset
    set_model(0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 1, 1);
    run_ticks("R7 stopped after reset", 5);

    // R10 load with simultaneous tick, then count from loaded value
    set_model(99, 59, 0, 0, 0, 0, 3, 15, 6, 10, 0, 0);
    do_load("R10 load beats tick", 1'b1);
    run_ticks("R10 R1 count from load", 1);

    // R8 all-ones image: reserved bits cleared, oscillator off so frozen (R7)
    @(negedge clk);
    load_valid = 1'b1; load_data = '1;
    @(posedge clk);
    @(negedge clk);
    load_valid = 1'b0;
    check("R8 zero bits", time_regs, 64'hFF1F3F37BF7F7FFF);
    for (int k = 0; k < 3; k++) begin
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R7 R8 frozen", time_regs, 64'hFF1F3F37BF7F7FFF);
    end
    tick = 1'b0;

    // R1 R2 R4 R6 long run across midnight and new year, 24-hour
    set_model(0, 0, 59, 23, 0, 0, 7, 31, 12, 99, 0, 1);
    do_load("R1 load", 1'b0);
    run_ticks("R1 R2 R4 R6 midnight run", 6005);

    // R3 12-hour run across midnight
    set_model(0, 59, 59, 11, 1, 1, 5, 31, 12, 45, 0, 0);
    do_load("R3 load", 1'b0);
    run_ticks("R3 R4 12h midnight run", 200);

    // R2 sweep every 24-hour value
    for (int h = 0; h < 24; h++) begin
      set_model(99, 59, 59, h, 0, 0, (h % 7) + 1, 10, 3, 7, 0, 0);
      do_load("R2 sweep load", 1'b0);
      run_ticks("R2 hour sweep", 1);
    end

    // R3 sweep every 12-hour value and both halves
    for (int p = 0; p < 2; p++) begin
      for (int h = 1; h <= 12; h++) begin
        set_model(99, 59, 59, h, p, 1, (h % 7) + 1, 28, 2, 1, 0, 0);
        do_load("R3 sweep load", 1'b0);
        run_ticks("R3 hour sweep", 1);
      end
    end

    // R4 month ends in a common and a leap year
    for (int y = 23; y <= 24; y++) begin
      for (int m = 1; m <= 12; m++) begin
        set_model(99, 59, 59, 23, 0, 0, (m % 7) + 1, days_in(m, y), m, y, 0, 0);
        do_load("R4 month load", 1'b0);
        run_ticks("R4 month end", 1);
      end
    end

    // R5 February 28 across all years
    for (int y = 0; y < 100; y++) begin
      set_model(99, 59, 59, 23, 0, 0, (y % 7) + 1, 28, 2, y, 0, 1);
      do_load("R5 feb load", 1'b0);
      run_ticks("R5 leap feb", 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule